// File: doc/BRIEF.md
# Frame-Synced Serial Byte Receiver with Programmable Data Delay

This block turns a framed serial bit stream into bytes. A frame begins on the first bit-clock cycle in which the frame-sync input is high. The receiver then waits a programmable number of bit clocks (zero, one or two) before it takes the first data bit. It collects eight bits, most significant first, and presents the finished byte with a one-clock valid strobe. After that it goes back to waiting for the next frame start.

The block runs on a fast system clock. A bit-clock enable marks the cycles in which serial data and frame sync are valid. The delay setting lives in a small configuration register that software writes through a write strobe. The all-ones code of that register is reserved. If it is programmed, the receiver uses the longest legal delay and raises a sticky error flag.

Top module: `framed_serial_rx`

## Requirements
- R1: After reset `word_valid` and `cfg_err` are 0, and the delay register holds code 00. A frame received without any configuration write therefore uses zero delay.
- R2: With delay code 00, the `ser_din` value sampled in the frame-start cycle (the first enabled cycle with `fsync` high while idle) becomes bit 7 of the word.
- R3: With delay code 01, bit 7 is taken from the first enabled cycle after the frame-start cycle.
- R4: With delay code 10, bit 7 is taken from the second enabled cycle after the frame-start cycle.
- R5: Writing code 11 makes the receiver behave exactly as with code 10. It also sets `cfg_err` one clock after the write. `cfg_err` then stays 1 until reset, even after a legal code is written.
- R6: Eight consecutive enabled data cycles are assembled most significant bit first. The first captured bit lands in `word_out[7]` and the last in `word_out[0]`.
- R7: In cycles with `bit_en` low, `fsync` and `ser_din` have no effect, and the delay and bit counts do not advance.
- R8: `word_valid` is high for exactly one clock, in the cycle after the clock edge that samples the eighth data bit. In that same cycle `word_out` holds the assembled byte.
- R9: `fsync` asserted during the delay or data phase of a frame is ignored. The word in progress completes unchanged, and a new frame can start on the first enabled cycle after the eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the delay register |
| cfg_dly | input | 2 | Delay code to write (00, 01, 10; 11 reserved) |
| bit_en | input | 1 | Bit-clock enable; serial inputs are sampled only when high |
| fsync | input | 1 | Frame-sync input |
| ser_din | input | 1 | Serial data input |
| word_out | output | 8 | Last received byte |
| word_valid | output | 1 | One-clock strobe marking a new byte on `word_out` |
| cfg_err | output | 1 | Sticky flag: reserved delay code was written |

## Verification
The byte result is due one clock after the rising edge that samples the eighth enabled data bit. `cfg_err` is due one clock after the rising edge that takes a write of code 11. The bench changes inputs on falling edges and reads outputs at the next falling edge, half a clock after the capturing edge. It expects `word_valid` at exactly that falling edge and expects it to be low at every other falling edge of the frame and at the one that follows. Random gaps of disabled cycles, filled with junk data and sync, are placed between enabled slots, so a wrong count of enabled cycles shows up as a shifted byte or a misplaced strobe.

// File: rtl/framed_serial_rx.sv
module framed_serial_rx #(
  parameter int WORD_W = 8,
  parameter int DLY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic              ser_din,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              cfg_err
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [DLY_W-1:0] RSVD    = '1;
  localparam logic [DLY_W-1:0] MAX_DLY = RSVD - 1'b1;
  localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_DATA} st_t;

  st_t               st_q;
  logic [DLY_W-1:0]  dly_q, gap_q, dly_eff;
  logic [CNT_W-1:0]  bit_q;
  logic [WORD_W-1:0] shreg_q, sh_next;
  logic              start, capture, last;

  assign dly_eff = (dly_q == RSVD) ? MAX_DLY : dly_q;
  assign start   = bit_en && (st_q == S_IDLE) && fsync;
  assign capture = bit_en && ((st_q == S_DATA) ||
                              (st_q == S_GAP && gap_q == '0) ||
                              (st_q == S_IDLE && fsync && dly_eff == '0));
  assign last    = bit_en && (st_q == S_DATA) && (bit_q == LAST_IX);
  assign sh_next = {shreg_q[WORD_W-2:0], ser_din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q   <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_wr) begin
      dly_q <= cfg_dly;
      if (cfg_dly == RSVD) cfg_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      gap_q <= '0;
      bit_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          if (dly_eff == '0) begin
            st_q  <= S_DATA;
            bit_q <= CNT_W'(1);
          end else begin
            st_q  <= S_GAP;
            gap_q <= dly_eff - 1'b1;
          end
        end
        S_GAP: if (bit_en) begin
          if (gap_q == '0) begin
            st_q  <= S_DATA;
            bit_q <= CNT_W'(1);
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        S_DATA: if (bit_en) begin
          bit_q <= bit_q + 1'b1;
          if (last) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      if (capture) shreg_q <= sh_next;
      word_valid <= last;
      if (last) word_out <= sh_next;
    end
  end

  // R8: strobe lasts a single clock
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R8: strobe only follows a data-phase cycle
  p_valid_from_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(st_q) == S_DATA);

  // R5: reserved write raises the flag
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dly == RSVD) |=> cfg_err);

  // R5: flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7: nothing advances without the bit-clock enable
  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(st_q) && $stable(bit_q) && $stable(gap_q) && $stable(shreg_q));

  // R9: a frame in its delay phase never falls back to idle
  p_gap_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_GAP |=> st_q != S_IDLE);

  // R2/R3/R4: the delay phase never lasts longer than the largest legal delay
  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_GAP |-> gap_q < MAX_DLY);
endmodule

// File: tb/framed_serial_rx_bench.sv
`timescale 1ns/1ps
module framed_serial_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_dly = 2'b00;
  logic       bit_en = 1'b0;
  logic       fsync = 1'b0;
  logic       ser_din = 1'b0;
  logic [7:0] word_out;
  logic       word_valid;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  logic [1:0] cur_code = 2'b00;

  always #2.5 clk = ~clk;

  framed_serial_rx u_framed_serial_rx (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dly(cfg_dly),
    .bit_en(bit_en), .fsync(fsync), .ser_din(ser_din),
    .word_out(word_out), .word_valid(word_valid), .cfg_err(cfg_err));

  function automatic int exp_delay(input logic [1:0] code);
    return (code == 2'b11) ? 2 : int'(code);
  endfunction

  function automatic logic exp_bit(input logic [7:0] b, input int slot, input int d);
    return b[7 - (slot - d)];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R8 quiet", word_valid, 0);
      bit_en = 1'b0; fsync = 1'($urandom); ser_din = 1'($urandom);
    end
  endtask

  task automatic set_cfg(input logic [1:0] code);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dly = code; bit_en = 1'b0; fsync = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    cur_code = code;
  endtask

  task automatic run_frame(input logic [7:0] b, input int max_gap, input bit junk_fs,
                           input int pre_idle, input string req);
    int d;
    d = exp_delay(cur_code);
    for (int i = 0; i < pre_idle; i++) begin
      @(negedge clk);
      check("R8 quiet", word_valid, 0);
      bit_en = 1'b1; fsync = 1'b0; ser_din = 1'($urandom);
    end
    for (int k = 0; k < d + 8; k++) begin
      idle_junk($urandom_range(0, max_gap));
      @(negedge clk);
      check("R8 quiet", word_valid, 0);
      bit_en = 1'b1;
      fsync = (k == 0) ? 1'b1 : (junk_fs ? 1'($urandom) : 1'b0);
      ser_din = (k >= d) ? exp_bit(b, k, d) : 1'($urandom);
    end
    @(negedge clk);
    check({req, " R8 strobe"}, word_valid, 1);
    check({req, " R6 byte"}, word_out, b);
    bit_en = 1'b0; fsync = 1'b0;
    @(negedge clk);
    check("R8 single pulse", word_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 valid", word_valid, 0);
    check("R1 err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", word_valid, 0);

    // R1 / R2: default delay 00, bit in frame-start cycle is B7
    run_frame(8'hA5, 0, 0, 2, "R1 R2");
    run_frame(8'h81, 2, 1, 0, "R2 gaps");

    set_cfg(2'b01);
    run_frame(8'h3C, 0, 0, 1, "R3");
    run_frame(8'hF0, 3, 1, 0, "R3 R7 R9");

    set_cfg(2'b10);
    run_frame(8'h5A, 0, 0, 0, "R4");
    run_frame(8'h01, 2, 1, 3, "R4 R7 R9");

    check("R5 no err yet", cfg_err, 0);
    set_cfg(2'b11);
    check("R5 err set", cfg_err, 1);
    run_frame(8'hC3, 0, 0, 0, "R5 as 10");
    run_frame(8'h7E, 2, 1, 1, "R5 R9");
    set_cfg(2'b01);
    check("R5 err sticky", cfg_err, 1);
    run_frame(8'h96, 1, 0, 0, "R5 back to 01");

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 3) == 0) set_cfg(2'($urandom_range(0, 2)));
      run_frame(8'($urandom), $urandom_range(0, 3), 1'($urandom),
                $urandom_range(0, 2), "R6 R7 R9 random");
    end
    check("R5 err still set", cfg_err, 1);

    // R1: reset clears the flag and returns the delay to 00
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 err cleared", cfg_err, 0);
    rst_n = 1'b1; cur_code = 2'b00;
    run_frame(8'h69, 1, 1, 0, "R1 delay 00 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule